// File: doc/BRIEF.md
# Descriptor Ring Master Controller

This block is the host-side control logic of a DMA-driven SMBus master. Software builds a ring of 16-byte descriptors in system memory, sets the ring's base address and size through a small register file, and posts work by moving a head index. The block walks the ring from its own tail index. For each entry it fetches the four descriptor words and passes the whole descriptor to a bus transaction sequencer. It then writes the sequencer's result back into the descriptor and moves on. The bus-level engine and the payload DMA live outside this block.

After each completion the block records status, received count and transmitted count in the descriptor, then advances the tail modulo the ring size. Two sticky flags record completions and errors. A descriptor that fails with its stop-on-error bit set halts the walk, and the tail stays on that entry so software can inspect it or retry it.

Top module: `dring_master`

## Requirements
- R1: The registers are decoded at these offsets: base address low word 0x100, base high word 0x104, control 0x108, status 0x10C, ring size 0x110 (entries minus one in bits 7:0, reset value 31), retry policy 0x114 (bits 7:0, stored only). Read data appears on `reg_rdata` the cycle after `reg_rd`. Unmapped offsets read as zero. All other registers reset to zero.
- R2: The control register holds the head index in bits 23:16, start in bit 0 and error-interrupt enable in bit 4, and reads back as written.
- R3: While start is 1 and tail differs from head, the block issues four 32-bit reads at base + 16·tail + 0, 4, 8 and 12. Each request holds its address until `mem_ack` arrives. Byte 0 of a descriptor is bits 7:0 of its first word.
- R4: The fetched descriptor is presented as `seq_desc` = {word3, word2, word1, word0}. `seq_valid` and `seq_desc` stay stable until `seq_ready`.
- R5: After `seq_done`, one write goes to base + 16·tail + 4 with byte enables 4'b1101. The data is {txcnt, rxcnt, unchanged, status}, so descriptor bytes 4, 6 and 7 are updated and byte 5 is not touched.
- R6: The tail advances only after the write-back is acknowledged, and wraps from the ring-size value to 0. It is read in status bits 23:16. The walk stops when tail equals head. No memory request is made while start is 0.
- R7: Status bit 0 (in progress) is 1 from the first fetch of a descriptor until its write-back completes.
- R8: A descriptor fails when bit 0 of the returned status is 0, and any failure sets the error flag (status bit 4). If bit 7 of descriptor byte 3 is set, the tail stays on the failing entry, start clears, and nothing more is fetched until start is written again.
- R9: The completion flag (status bit 5) is set after the write-back of any descriptor whose byte 3 bit 6 is set, whether or not it failed.
- R10: Writing 1 to status bit 5 or bit 4 clears that flag, and writing 0 leaves it. A hardware set in the same cycle wins over the clear. The tail and in-progress fields ignore writes.
- R11: `irq` equals completion flag OR (error flag AND error-interrupt enable), registered one cycle after the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| mem_req | output | 1 | Descriptor memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Byte address of the 32-bit word |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| seq_valid | output | 1 | Descriptor offered to the sequencer |
| seq_ready | input | 1 | Sequencer accepts the descriptor |
| seq_desc | output | 128 | Full descriptor, byte 0 in bits 7:0 |
| seq_done | input | 1 | Transaction finished (one-cycle pulse) |
| seq_status | input | 8 | Result status, bit 0 = success |
| seq_rxcnt | input | 8 | Bytes received |
| seq_txcnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted tail or a bad wrap computation is visible at once, on the very next read request: its address falls outside base + 16·tail. The reference model predicts every request address, descriptor hand-off and write-back word, so such an error is reported in the cycle it reaches the bus. Flag or enable errors show on `irq` two clocks after the event that should have changed them, and the bench compares that output on every clock. A halt that fails to stop the walk shows as an unexpected fetch. A walk that never starts shows as a stuck status.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // register offsets (byte addresses)
  localparam logic [11:0] OFS_BASE_LO = 12'h100;
  localparam logic [11:0] OFS_BASE_HI = 12'h104;
  localparam logic [11:0] OFS_CTRL    = 12'h108;
  localparam logic [11:0] OFS_STAT    = 12'h10C;
  localparam logic [11:0] OFS_SIZE    = 12'h110;
  localparam logic [11:0] OFS_RETRY   = 12'h114;

  // control / status bit positions
  localparam int CT_START = 0;
  localparam int CT_EIE   = 4;
  localparam int IDX_LSB  = 16;
  localparam int ST_BUSY  = 0;
  localparam int ST_ERR   = 4;
  localparam int ST_CMP   = 5;

  // descriptor byte-3 flags and result status bit
  localparam int DC_IRQ = 6;
  localparam int DC_SOE = 7;
  localparam int DS_OK  = 0;

  localparam int DESC_WORDS = 4;
  localparam logic [3:0] WB_MASK = 4'b1101;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_ISSUE,
    W_WAIT,
    W_WBACK
  } walk_state_t;

endpackage

// File: rtl/dring_addr_gen.sv
module dring_addr_gen #(
  parameter int MEM_AW = 64,
  parameter int IDX_W  = 8
) (
  input  logic [MEM_AW-1:0] base,
  input  logic [IDX_W-1:0]  tail,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [MEM_AW-1:0] desc_addr,
  output logic [IDX_W-1:0]  tail_next
);
  localparam int ENTRY_SHIFT = 4;

  always_comb begin
    desc_addr = base + (MEM_AW'(tail) << ENTRY_SHIFT);
    tail_next = (tail == last_idx) ? '0 : tail + 1'b1;
  end
endmodule

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int MEM_AW = 64,
  parameter int IDX_W  = 8,
  parameter int DEF_LAST = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  tail,
  input  logic              busy,
  input  logic              set_comp,
  input  logic              set_err,
  input  logic              clr_start,
  output logic [MEM_AW-1:0] base,
  output logic [IDX_W-1:0]  last_idx,
  output logic [IDX_W-1:0]  head,
  output logic              start,
  output logic              irq
);
  logic [63:0]      base_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] head_q;
  logic [7:0]       retry_q;
  logic             start_q, eie_q, comp_q, err_q;
  logic [31:0]      rd_mux;

  assign base     = base_q[MEM_AW-1:0];
  assign last_idx = last_q;
  assign head     = head_q;
  assign start    = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      last_q  <= IDX_W'(DEF_LAST);
      head_q  <= '0;
      retry_q <= '0;
      start_q <= 1'b0;
      eie_q   <= 1'b0;
      comp_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (clr_start) start_q <= 1'b0;
      if (reg_wr) begin
        if (reg_addr == REG_AW'(OFS_BASE_LO)) base_q[31:0]  <= reg_wdata;
        if (reg_addr == REG_AW'(OFS_BASE_HI)) base_q[63:32] <= reg_wdata;
        if (reg_addr == REG_AW'(OFS_CTRL)) begin
          head_q  <= reg_wdata[IDX_LSB +: IDX_W];
          start_q <= reg_wdata[CT_START];
          eie_q   <= reg_wdata[CT_EIE];
        end
        if (reg_addr == REG_AW'(OFS_STAT)) begin
          if (reg_wdata[ST_CMP]) comp_q <= 1'b0;
          if (reg_wdata[ST_ERR]) err_q  <= 1'b0;
        end
        if (reg_addr == REG_AW'(OFS_SIZE))  last_q  <= reg_wdata[IDX_W-1:0];
        if (reg_addr == REG_AW'(OFS_RETRY)) retry_q <= reg_wdata[7:0];
      end
      // hardware set has priority over a same-cycle clear
      if (set_comp) comp_q <= 1'b1;
      if (set_err)  err_q  <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(OFS_BASE_LO)) rd_mux = base_q[31:0];
    if (reg_addr == REG_AW'(OFS_BASE_HI)) rd_mux = base_q[63:32];
    if (reg_addr == REG_AW'(OFS_CTRL)) begin
      rd_mux[IDX_LSB +: IDX_W] = head_q;
      rd_mux[CT_START]         = start_q;
      rd_mux[CT_EIE]           = eie_q;
    end
    if (reg_addr == REG_AW'(OFS_STAT)) begin
      rd_mux[IDX_LSB +: IDX_W] = tail;
      rd_mux[ST_CMP]           = comp_q;
      rd_mux[ST_ERR]           = err_q;
      rd_mux[ST_BUSY]          = busy;
    end
    if (reg_addr == REG_AW'(OFS_SIZE))  rd_mux[IDX_W-1:0] = last_q;
    if (reg_addr == REG_AW'(OFS_RETRY)) rd_mux[7:0]       = retry_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? rd_mux : '0;
      irq       <= comp_q | (err_q & eie_q);
    end
  end
endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dring_pkg::*;
#(
  parameter int MEM_AW = 64,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  head,
  input  logic [MEM_AW-1:0] desc_addr,
  input  logic [IDX_W-1:0]  tail_next,
  output logic [IDX_W-1:0]  tail,
  output logic              busy,
  output logic              set_comp,
  output logic              set_err,
  output logic              clr_start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic [32*DESC_WORDS-1:0] seq_desc,
  input  logic              seq_done,
  input  logic [7:0]        seq_status,
  input  logic [7:0]        seq_rxcnt,
  input  logic [7:0]        seq_txcnt
);
  localparam int WI_W = $clog2(DESC_WORDS);

  walk_state_t     state;
  logic [31:0]     dw [DESC_WORDS];
  logic [WI_W-1:0] wi;
  logic [7:0]      res_q;
  logic [7:0]      dctl;
  logic            wb_fin, failed, halt;

  genvar g;
  generate
    for (g = 0; g < DESC_WORDS; g++) begin : g_pack
      assign seq_desc[32*g +: 32] = dw[g];
    end
  endgenerate

  assign dctl      = dw[0][31:24];
  assign wb_fin    = (state == W_WBACK) && mem_ack;
  assign failed    = !res_q[DS_OK];
  assign halt      = failed && dctl[DC_SOE];
  assign set_comp  = wb_fin && dctl[DC_IRQ];
  assign set_err   = wb_fin && failed;
  assign clr_start = wb_fin && halt;
  assign busy      = (state != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      tail      <= '0;
      wi        <= '0;
      res_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      seq_valid <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
    end else begin
      case (state)
        W_IDLE: begin
          if (start && (tail != head)) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_be   <= 4'hF;
            mem_addr <= desc_addr;
            wi       <= '0;
            state    <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (mem_ack) begin
            dw[wi] <= mem_rdata;
            if (wi == WI_W'(DESC_WORDS - 1)) begin
              mem_req   <= 1'b0;
              seq_valid <= 1'b1;
              state     <= W_ISSUE;
            end else begin
              wi       <= wi + 1'b1;
              mem_addr <= mem_addr + MEM_AW'(4);
            end
          end
        end
        W_ISSUE: begin
          if (seq_ready) begin
            seq_valid <= 1'b0;
            state     <= W_WAIT;
          end
        end
        W_WAIT: begin
          if (seq_done) begin
            res_q     <= seq_status;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= WB_MASK;
            mem_addr  <= desc_addr + MEM_AW'(4);
            mem_wdata <= {seq_txcnt, seq_rxcnt, dw[1][15:8], seq_status};
            state     <= W_WBACK;
          end
        end
        W_WBACK: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (!halt) tail <= tail_next;
            state   <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_master.sv
module dring_master
  import dring_pkg::*;
#(
  parameter int REG_AW   = 12,
  parameter int MEM_AW   = 64,
  parameter int IDX_W    = 8,
  parameter int DEF_LAST = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic [127:0]      seq_desc,
  input  logic              seq_done,
  input  logic [7:0]        seq_status,
  input  logic [7:0]        seq_rxcnt,
  input  logic [7:0]        seq_txcnt,
  output logic              irq
);
  logic [MEM_AW-1:0] ring_base, ring_desc_addr;
  logic [IDX_W-1:0]  ring_last, ring_head, ring_tail, ring_tail_next;
  logic              ring_start, ring_busy;
  logic              hw_set_comp, hw_set_err, hw_clr_start;

  dring_regs #(
    .REG_AW(REG_AW), .MEM_AW(MEM_AW), .IDX_W(IDX_W), .DEF_LAST(DEF_LAST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tail(ring_tail), .busy(ring_busy),
    .set_comp(hw_set_comp), .set_err(hw_set_err), .clr_start(hw_clr_start),
    .base(ring_base), .last_idx(ring_last), .head(ring_head),
    .start(ring_start), .irq(irq)
  );

  dring_addr_gen #(.MEM_AW(MEM_AW), .IDX_W(IDX_W)) u_agen (
    .base(ring_base), .tail(ring_tail), .last_idx(ring_last),
    .desc_addr(ring_desc_addr), .tail_next(ring_tail_next)
  );

  dring_walker #(.MEM_AW(MEM_AW), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst(rst),
    .start(ring_start), .head(ring_head),
    .desc_addr(ring_desc_addr), .tail_next(ring_tail_next),
    .tail(ring_tail), .busy(ring_busy),
    .set_comp(hw_set_comp), .set_err(hw_set_err), .clr_start(hw_clr_start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_desc(seq_desc),
    .seq_done(seq_done), .seq_status(seq_status),
    .seq_rxcnt(seq_rxcnt), .seq_txcnt(seq_txcnt)
  );
endmodule

// File: rtl/dring_master_chk.sv
module dring_master_chk #(
  parameter int MEM_AW = 64,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              seq_valid,
  input logic              seq_ready,
  input logic [127:0]      seq_desc,
  input logic [IDX_W-1:0]  tail,
  input logic              busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    seq_valid && !seq_ready |=> seq_valid && $stable(seq_desc)); // R4

  AST_WB_MASK: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_be == 4'b1101); // R5

  AST_TAIL_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail) |-> $past(mem_req && mem_we && mem_ack)); // R6

  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail) |-> (tail == IDX_W'($past(tail) + 1'b1)) || (tail == '0)); // R6

  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R7
endmodule

bind dring_master dring_master_chk #(.MEM_AW(MEM_AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_be(mem_be),
  .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_desc(seq_desc),
  .tail(ring_tail), .busy(ring_busy)
);

// File: tb/dring_master_test.sv
`timescale 1ns/1ps
module dring_master_test;
  localparam logic [63:0] BASE = 64'h0000_00A5_0000_4000;

  logic         clk = 0, rst = 1;
  logic         reg_wr = 0, reg_rd = 0;
  logic [11:0]  reg_addr = 0;
  logic [31:0]  reg_wdata = 0, reg_rdata;
  logic         mem_req, mem_we, mem_ack = 0;
  logic [63:0]  mem_addr;
  logic [3:0]   mem_be;
  logic [31:0]  mem_wdata, mem_rdata = 0;
  logic         seq_valid, seq_ready = 0, seq_done = 0;
  logic [127:0] seq_desc;
  logic [7:0]   seq_status = 0, seq_rxcnt = 0, seq_txcnt = 0;
  logic         irq;

  dring_master uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_desc(seq_desc),
    .seq_done(seq_done), .seq_status(seq_status), .seq_rxcnt(seq_rxcnt),
    .seq_txcnt(seq_txcnt), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  logic [31:0] bmem [0:255];
  int   m_tail = 0, m_head = 0, m_size = 31;
  bit   m_start = 0, m_ie = 0, m_comp = 0, m_err = 0;
  int   rd_idx = 0, seq_n = 0, cnt = 0, done_delay = 2, req_count = 0;
  bit   seq_busy = 0;
  logic [7:0] cur_st = 0, cur_rx = 0, cur_tx = 0, cur_ctrl = 0;
  logic [7:0] resp_q [$];
  int   n_cmp = 0, n_bad = 0;
  logic s1 = 0, s2 = 0;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int widx(int t, int w);
    return (t * 4 + w) & 255;
  endfunction

  // memory and sequencer responders plus model updates
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; seq_ready = 0; seq_done = 0; seq_busy = 0; cnt = 0; rd_idx = 0;
    end else begin
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        req_count++;
        if (!mem_we) begin
          check("R3 fetch address", 128'(mem_addr), 128'(BASE + 64'(m_tail * 16 + rd_idx * 4)));
          mem_rdata = bmem[widx(m_tail, rd_idx)];
          rd_idx = (rd_idx + 1) % 4;
        end else begin
          automatic int w = widx(m_tail, 1);
          check("R5 write-back", {28'h0, mem_addr, mem_be, mem_wdata},
                {28'h0, BASE + 64'(m_tail * 16 + 4), 4'b1101, cur_tx, cur_rx, bmem[w][15:8], cur_st});
          bmem[w][7:0]   = mem_wdata[7:0];
          bmem[w][31:16] = mem_wdata[31:16];
          if (cur_ctrl[6]) m_comp = 1;
          if (!cur_st[0]) m_err = 1;
          if (!cur_st[0] && cur_ctrl[7]) m_start = 0;
          else m_tail = (m_tail == m_size) ? 0 : m_tail + 1;
        end
        mem_ack = 1;
      end
      if (seq_done) seq_done = 0;
      if (seq_ready) begin
        seq_ready = 0; cnt = done_delay;
      end else if (seq_valid && !seq_busy) begin
        check("R4 descriptor", seq_desc, {bmem[widx(m_tail,3)], bmem[widx(m_tail,2)],
                                           bmem[widx(m_tail,1)], bmem[widx(m_tail,0)]});
        cur_ctrl = bmem[widx(m_tail,0)][31:24];
        seq_ready = 1; seq_busy = 1;
      end else if (seq_busy && cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          cur_st = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h01;
          cur_rx = 8'(8'h40 + seq_n);
          cur_tx = 8'(8'h80 + seq_n);
          seq_n++;
          seq_status = cur_st; seq_rxcnt = cur_rx; seq_txcnt = cur_tx;
          seq_done = 1; seq_busy = 0;
        end
      end
    end
  end

  // interrupt prediction, compared on every clock (R11)
  always @(posedge clk) begin
    s1 <= rst ? 1'b0 : (m_comp | (m_err & m_ie));
    s2 <= rst ? 1'b0 : s1;
  end
  always @(negedge clk) if (!rst) check("R11 irq", 128'(irq), 128'(s2));

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    case (a)
      12'h108: begin m_head = int'(d[23:16]); m_start = d[0]; m_ie = d[4]; end
      12'h10C: begin if (d[5]) m_comp = 0; if (d[4]) m_err = 0; end
      12'h110: m_size = int'(d[7:0]);
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; reg_rd = 0;
  endtask

  task automatic expect_reg(string req, logic [11:0] a, logic [31:0] exp, logic [31:0] mask);
    logic [31:0] d;
    rd(a, d);
    check(req, 128'(d & mask), 128'(exp & mask));
  endtask

  function automatic logic [31:0] stat_exp(bit busy);
    return {8'h00, 8'(m_tail), 10'h0, m_comp, m_err, 3'b000, busy};
  endfunction

  function automatic logic [31:0] ctrl_exp();
    return {8'h00, 8'(m_head), 11'h0, m_ie, 3'b000, m_start};
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (!(m_tail == m_head || !m_start) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 5000) check("R6 walk finished", 128'(0), 128'(1));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c0;
    for (int t = 0; t < 64; t++) begin
      bmem[widx(t,0)] = {((t % 2) == 0) ? 8'h40 : 8'h00, 8'(t), 8'(t + 1), 8'(8'hA0 + t)};
      bmem[widx(t,1)] = {8'hEE, 8'hDD, 8'(t), 8'hCC};
      bmem[widx(t,2)] = 32'h1000_0000 + t;
      bmem[widx(t,3)] = 32'hFFFF_0000 | t;
    end
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset values and decode
    expect_reg("R1 size reset", 12'h110, 32'd31, 32'hFFFF_FFFF);
    expect_reg("R1 ctrl reset", 12'h108, 32'h0, 32'hFFFF_FFFF);
    expect_reg("R1 status reset", 12'h10C, 32'h0, 32'hFFFF_FFFF);
    expect_reg("R1 base reset", 12'h100, 32'h0, 32'hFFFF_FFFF);
    wr(12'h100, BASE[31:0]);
    wr(12'h104, BASE[63:32]);
    wr(12'h114, 32'h35);
    wr(12'h200, 32'hDEAD_BEEF);
    expect_reg("R1 base low", 12'h100, BASE[31:0], 32'hFFFF_FFFF);
    expect_reg("R1 base high", 12'h104, BASE[63:32], 32'hFFFF_FFFF);
    expect_reg("R1 retry policy", 12'h114, 32'h35, 32'hFFFF_FFFF);
    expect_reg("R1 unmapped", 12'h200, 32'h0, 32'hFFFF_FFFF);

    // R2 R3 R5 R9: three descriptors, entries 0 and 2 request completion
    wr(12'h108, 32'h0003_0011);
    expect_reg("R2 ctrl readback", 12'h108, ctrl_exp(), 32'hFFFF_FFFF);
    wait_idle();
    expect_reg("R9 status after three", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R5 descriptor bytes in memory", 128'(bmem[widx(1,1)]), 128'({8'h81, 8'h41, 8'h01, 8'h01}));
    check("R11 irq on completion", 128'(irq), 128'(1));

    // R10 clear on write one only
    wr(12'h10C, 32'h0000_0000);
    expect_reg("R10 write zero keeps flag", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    wr(12'h10C, 32'h00FF_0021);
    expect_reg("R10 write one clears, tail read-only", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R10 comp cleared", 128'(m_comp), 128'(0));

    // R6 nothing fetched while start is clear
    wr(12'h108, 32'h0005_0010);
    c0 = req_count;
    repeat (20) @(negedge clk);
    check("R6 no fetch without start", 128'(req_count), 128'(c0));
    expect_reg("R6 idle tail", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    wr(12'h108, 32'h0005_0011);
    wait_idle();
    expect_reg("R6 tail reaches head", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);

    // R7 in-progress while the sequencer is slow
    done_delay = 40;
    wr(12'h108, 32'h0006_0011);
    repeat (10) @(negedge clk);
    expect_reg("R7 in progress", 12'h10C, {8'h00, 8'd5, 15'h0, 1'b1}, 32'h00FF_0001);
    wait_idle();
    done_delay = 2;
    expect_reg("R7 done", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    wr(12'h10C, 32'h30);

    // R8 failure without stop: tail moves on, error flag set
    resp_q.push_back(8'h08);
    wr(12'h108, 32'h0007_0011);
    wait_idle();
    expect_reg("R8 error no stop", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R8 tail advanced", 128'(m_tail), 128'(7));
    wr(12'h10C, 32'h30);

    // R8 failure with stop: tail stays, start clears
    bmem[widx(7,0)][31:24] = 8'h80;
    resp_q.push_back(8'h04);
    wr(12'h108, 32'h0009_0011);
    wait_idle();
    expect_reg("R8 halted on entry", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R8 tail held", 128'(m_tail), 128'(7));
    expect_reg("R8 start cleared", 12'h108, ctrl_exp(), 32'hFFFF_FFFF);
    c0 = req_count;
    repeat (20) @(negedge clk);
    check("R8 no fetch after halt", 128'(req_count), 128'(c0));
    wr(12'h10C, 32'h30);
    wr(12'h108, 32'h0009_0011);
    wait_idle();
    expect_reg("R8 resumed", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);

    // R11 error with interrupt disabled
    wr(12'h10C, 32'h30);
    resp_q.push_back(8'h10);
    wr(12'h108, 32'h000A_0001);
    wait_idle();
    expect_reg("R11 err flag only", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R11 irq masked", 128'(irq), 128'(0));
    wr(12'h10C, 32'h30);

    // R6 wrap with a 12-entry ring
    wr(12'h110, 32'd11);
    expect_reg("R1 size write", 12'h110, 32'd11, 32'hFFFF_FFFF);
    wr(12'h108, 32'h0002_0011);
    wait_idle();
    expect_reg("R6 wrap", 12'h10C, stat_exp(0), 32'hFFFF_FFFF);
    check("R6 wrapped tail", 128'(m_tail), 128'(2));

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule